// File: doc/BRIEF.md
# Execute Stage with Blocking Load

This block is the execute stage of a small in-order pipeline. Each cycle it can take one decoded instruction from an upstream valid/ready channel. An instruction carries an opcode, two operand values and the sequential next-PC value. The stage turns it into a single result that goes to a writeback channel. Conditional absolute jumps pick either the first operand or the next PC. Add and emit produce the operand sum. Any other opcode passes through with a zero result.

A load adds its operands to form an effective address. It sends the cache-line number of that address on a memory command channel and parks in a one-entry stall slot. When the line comes back on the memory response channel, the stage picks eight bytes starting at the address's offset within the line. It packs them little-endian into a 64-bit word and sends that to writeback. While the slot holds a load, no new instruction is taken, so at most one memory read is in flight.

All four channels use valid/ready. Both outgoing channels are registered and hold their contents while the receiver stalls.

Top module: `exec_stage`

## Requirements
- R1: Opcode 4'h1 (jump if zero) gives the first operand when the second operand is zero, and the next PC otherwise.
- R2: Opcode 4'h2 (jump if nonzero) gives the first operand when the second operand is nonzero, and the next PC otherwise.
- R3: Opcodes 4'h3 (add) and 4'h4 (emit) both give the 64-bit sum of the operands, modulo 2^64.
- R4: Any opcode other than 4'h1 to 4'h5 is sent to writeback with a zero result. The opcode field is copied unchanged to `wb_opcode` for every instruction.
- R5: A load (opcode 4'h5) drives `mc_valid` one cycle after it is accepted. `mc_line_addr` equals (op_a + op_b) >> 6, because a line is 64 bytes. A load never produces a writeback at issue.
- R6: The load result is eight line bytes starting at byte offset (op_a + op_b) & 63. The byte at that offset goes in result bits 7:0, and each following byte goes 8 bits higher. Byte k of `mr_line` is bits 8k+7:8k. Windows that cross the end of the line are undefined.
- R7: `in_ready` is high only when the stall slot is empty and both outgoing registers are empty or being drained in that cycle.
- R8: While the slot holds a load, `in_ready` stays low and the slot is serviced first. `mr_ready` is high only while a load is parked and writeback can accept. At most one memory command is outstanding.
- R9: `wb_valid` with `wb_result`/`wb_opcode`, and `mc_valid` with `mc_line_addr`, stay unchanged while their ready input is low.
- R10: A synchronous active-high reset empties the slot and clears `wb_valid` and `mc_valid`.
- R11: A non-load result appears on writeback in the cycle after the instruction is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction accepted this cycle |
| in_opcode | input | 4 | Operation code |
| in_op_a | input | 64 | First operand |
| in_op_b | input | 64 | Second operand |
| in_next_pc | input | 64 | Sequential next PC |
| wb_valid | output | 1 | Writeback entry present |
| wb_ready | input | 1 | Writeback consumer accepts |
| wb_opcode | output | 4 | Opcode of the written-back instruction |
| wb_result | output | 64 | Result value |
| mc_valid | output | 1 | Memory read command present |
| mc_ready | input | 1 | Memory accepts command |
| mc_line_addr | output | 58 | Line number to read |
| mr_valid | input | 1 | Line data returned |
| mr_ready | output | 1 | Stage takes the returned line |
| mr_line | input | 512 | Returned line, byte k in bits 8k+7:8k |

## Verification
The bench builds the stage with its default 64-byte line, which gives a 6-bit offset and a 58-bit line number. With these values, loads at offsets 0, 3, 13 and 56 are reachable. Offset 56 is the last window that fits in the line. A bench memory model fills every byte of a line with a distinct value derived from the line number, so any byte that lands in the wrong lane shows up. Memory latency, writeback stalls and command stalls are varied, which brings the slot-priority, hold-under-stall and single-outstanding behaviour within reach.

// File: rtl/exec_pkg.sv
package exec_pkg;

    localparam int unsigned XLEN       = 64;
    localparam int unsigned OPC_W      = 4;
    localparam int unsigned WORD_BYTES = XLEN / 8;

    typedef enum logic [OPC_W-1:0] {
        OPC_JMP_Z  = 4'h1,
        OPC_JMP_NZ = 4'h2,
        OPC_ADD    = 4'h3,
        OPC_EMIT   = 4'h4,
        OPC_LOAD   = 4'h5
    } opc_e;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic [XLEN-1:0]  a;
        logic [XLEN-1:0]  b;
        logic [XLEN-1:0]  next_pc;
    } issue_t;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic [XLEN-1:0]  value;
    } wb_t;

    function automatic logic opc_is_load(input logic [OPC_W-1:0] opc);
        return opc == OPC_LOAD;
    endfunction

endpackage

// File: rtl/exec_alu.sv
module exec_alu
    import exec_pkg::*;
(
    input  issue_t          op,
    output logic [XLEN-1:0] result,
    output logic [XLEN-1:0] eff_addr
);
    logic [XLEN-1:0] sum;
    logic            b_zero;

    assign sum      = op.a + op.b;
    assign b_zero   = (op.b == '0);
    assign eff_addr = sum;

    always_comb begin
        result = '0;
        case (op.opc)
            OPC_JMP_Z:  result = b_zero ? op.a : op.next_pc;
            OPC_JMP_NZ: result = b_zero ? op.next_pc : op.a;
            OPC_ADD,
            OPC_EMIT:   result = sum;
            default:    result = '0;
        endcase
    end
endmodule

// File: rtl/exec_line_pick.sv
module exec_line_pick
    import exec_pkg::*;
#(
    parameter int unsigned LINE_BYTES = 64,
    localparam int unsigned OFS_W     = $clog2(LINE_BYTES),
    localparam int unsigned LINE_W    = LINE_BYTES * 8
) (
    input  logic [LINE_W-1:0] line,
    input  logic [OFS_W-1:0]  offset,
    output logic [XLEN-1:0]   word
);
    for (genvar k = 0; k < WORD_BYTES; k++) begin : g_lane
        logic [OFS_W-1:0] idx;
        logic [OFS_W+2:0] bitpos;
        assign idx    = offset + OFS_W'(k);
        assign bitpos = {idx, 3'b000};
        assign word[k*8 +: 8] = line[bitpos +: 8];
    end
endmodule

// File: rtl/exec_load_slot.sv
module exec_load_slot
    import exec_pkg::*;
#(
    parameter int unsigned OFS_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             park,
    input  logic [OPC_W-1:0] park_opc,
    input  logic [OFS_W-1:0] park_ofs,
    input  logic             done,
    output logic             busy,
    output logic [OPC_W-1:0] held_opc,
    output logic [OFS_W-1:0] held_ofs
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            held_opc <= '0;
            held_ofs <= '0;
        end else if (park) begin
            busy     <= 1'b1;
            held_opc <= park_opc;
            held_ofs <= park_ofs;
        end else if (done) begin
            busy     <= 1'b0;
        end
    end
endmodule

// File: rtl/exec_stage.sv
module exec_stage
    import exec_pkg::*;
#(
    parameter int unsigned LINE_BYTES = 64,
    localparam int unsigned OFS_W     = $clog2(LINE_BYTES),
    localparam int unsigned LINE_W    = LINE_BYTES * 8,
    localparam int unsigned LA_W      = XLEN - OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [OPC_W-1:0]  in_opcode,
    input  logic [XLEN-1:0]   in_op_a,
    input  logic [XLEN-1:0]   in_op_b,
    input  logic [XLEN-1:0]   in_next_pc,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [OPC_W-1:0]  wb_opcode,
    output logic [XLEN-1:0]   wb_result,
    output logic              mc_valid,
    input  logic              mc_ready,
    output logic [LA_W-1:0]   mc_line_addr,
    input  logic              mr_valid,
    output logic              mr_ready,
    input  logic [LINE_W-1:0] mr_line
);
    issue_t           cur;
    logic [XLEN-1:0]  alu_res;
    logic [XLEN-1:0]  eaddr;
    logic [XLEN-1:0]  load_word;
    logic             slot_valid;
    logic [OPC_W-1:0] slot_opc;
    logic [OFS_W-1:0] slot_ofs;
    logic             wb_free, mc_free;
    logic             take, take_load, finish, wb_load;
    wb_t              wb_q, wb_d;

    assign cur = '{opc: in_opcode, a: in_op_a, b: in_op_b, next_pc: in_next_pc};

    exec_alu u_alu (
        .op       (cur),
        .result   (alu_res),
        .eff_addr (eaddr)
    );

    exec_load_slot #(.OFS_W(OFS_W)) u_slot (
        .clk      (clk),
        .rst      (rst),
        .park     (take_load),
        .park_opc (in_opcode),
        .park_ofs (eaddr[OFS_W-1:0]),
        .done     (finish),
        .busy     (slot_valid),
        .held_opc (slot_opc),
        .held_ofs (slot_ofs)
    );

    exec_line_pick #(.LINE_BYTES(LINE_BYTES)) u_pick (
        .line   (mr_line),
        .offset (slot_ofs),
        .word   (load_word)
    );

    // Handshake control: slot service outranks new issue.
    assign wb_free   = !wb_valid || wb_ready;
    assign mc_free   = !mc_valid || mc_ready;
    assign in_ready  = !slot_valid && wb_free && mc_free;
    assign take      = in_valid && in_ready;
    assign take_load = take && opc_is_load(in_opcode);
    assign mr_ready  = slot_valid && wb_free;
    assign finish    = mr_ready && mr_valid;
    assign wb_load   = finish || (take && !opc_is_load(in_opcode));

    always_comb begin
        if (finish) wb_d = '{opc: slot_opc, value: load_word};
        else        wb_d = '{opc: in_opcode, value: alu_res};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_valid <= 1'b0;
            wb_q     <= '0;
        end else if (wb_load) begin
            wb_valid <= 1'b1;
            wb_q     <= wb_d;
        end else if (wb_ready) begin
            wb_valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mc_valid     <= 1'b0;
            mc_line_addr <= '0;
        end else if (take_load) begin
            mc_valid     <= 1'b1;
            mc_line_addr <= eaddr[XLEN-1:OFS_W];
        end else if (mc_ready) begin
            mc_valid     <= 1'b0;
        end
    end

    assign wb_opcode = wb_q.opc;
    assign wb_result = wb_q.value;
endmodule

// File: rtl/exec_stage_chk.sv
module exec_stage_chk
    import exec_pkg::*;
#(
    parameter int unsigned LA_W = 58
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic [OPC_W-1:0] in_opcode,
    input logic             wb_valid,
    input logic             wb_ready,
    input logic [OPC_W-1:0] wb_opcode,
    input logic [XLEN-1:0]  wb_result,
    input logic             mc_valid,
    input logic             mc_ready,
    input logic [LA_W-1:0]  mc_line_addr,
    input logic             mr_valid,
    input logic             mr_ready
);
    logic [1:0] outstanding;
    logic       cmd_hs, rsp_hs;

    assign cmd_hs = mc_valid && mc_ready;
    assign rsp_hs = mr_valid && mr_ready;

    always_ff @(posedge clk) begin
        if (rst) outstanding <= '0;
        else     outstanding <= outstanding + {1'b0, cmd_hs} - {1'b0, rsp_hs};
    end

    // R8: one request in flight at most
    a_r8_single_outstanding: assert property (@(posedge clk) disable iff (rst)
        outstanding <= 2'd1);

    // R8: issue blocked while a line is awaited
    a_r8_no_issue_waiting: assert property (@(posedge clk) disable iff (rst)
        (outstanding != 2'd0) |-> !in_ready);

    // R8: response taken only when writeback has room
    a_r8_rsp_gated: assert property (@(posedge clk) disable iff (rst)
        mr_ready |-> (!wb_valid || wb_ready));

    // R5: accepted load raises a command next cycle
    a_r5_load_cmd: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_opcode == OPC_LOAD) |=> mc_valid);

    // R9: stalled writeback holds
    a_r9_wb_hold: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_result) && $stable(wb_opcode)));

    // R9: stalled command holds
    a_r9_mc_hold: assert property (@(posedge clk) disable iff (rst)
        (mc_valid && !mc_ready) |=> (mc_valid && $stable(mc_line_addr)));

    // R10: reset clears outgoing valids
    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> (!wb_valid && !mc_valid));
endmodule

bind exec_stage exec_stage_chk #(.LA_W(LA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_opcode    (in_opcode),
    .wb_valid     (wb_valid),
    .wb_ready     (wb_ready),
    .wb_opcode    (wb_opcode),
    .wb_result    (wb_result),
    .mc_valid     (mc_valid),
    .mc_ready     (mc_ready),
    .mc_line_addr (mc_line_addr),
    .mr_valid     (mr_valid),
    .mr_ready     (mr_ready)
);

// File: tb/tb_exec_stage.sv
`timescale 1ns/1ps
module tb_exec_stage;
    localparam int LINE_BYTES = 64;
    localparam int LA_W       = 58;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         in_ready;
    logic [3:0]   in_opcode;
    logic [63:0]  in_op_a, in_op_b, in_next_pc;
    logic         wb_valid, wb_ready;
    logic [3:0]   wb_opcode;
    logic [63:0]  wb_result;
    logic         mc_valid, mc_ready;
    logic [LA_W-1:0] mc_line_addr;
    logic         mr_valid, mr_ready;
    logic [511:0] mr_line;

    int vectors = 0;
    int miscompares = 0;
    int mem_lat = 2;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    exec_stage dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_opcode(in_opcode),
        .in_op_a(in_op_a), .in_op_b(in_op_b), .in_next_pc(in_next_pc),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_opcode(wb_opcode), .wb_result(wb_result),
        .mc_valid(mc_valid), .mc_ready(mc_ready), .mc_line_addr(mc_line_addr),
        .mr_valid(mr_valid), .mr_ready(mr_ready), .mr_line(mr_line)
    );

    function automatic logic [7:0] line_byte(input logic [LA_W-1:0] la, input int i);
        return (la[7:0] ^ 8'hA5) + 8'(i * 7);
    endfunction

    function automatic logic [511:0] mk_line(input logic [LA_W-1:0] la);
        logic [511:0] l;
        for (int i = 0; i < LINE_BYTES; i++) l[i*8 +: 8] = line_byte(la, i);
        return l;
    endfunction

    function automatic logic [63:0] exp_word(input logic [63:0] ea);
        logic [63:0] w = '0;
        for (int k = 0; k < 8; k++)
            w[k*8 +: 8] = line_byte(ea[63:6], int'(ea[5:0]) + k);
        return w;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Memory model
    initial begin
        logic [LA_W-1:0] la;
        mr_valid = 1'b0;
        mr_line  = '0;
        forever begin
            @(negedge clk); #1;
            if (mc_valid && mc_ready) begin
                la = mc_line_addr;
                @(negedge clk);
                repeat (mem_lat) @(negedge clk);
                mr_line  = mk_line(la);
                mr_valid = 1'b1;
                #1;
                while (!mr_ready) begin @(negedge clk); #1; end
                @(negedge clk);
                mr_valid = 1'b0;
            end
        end
    end

    task automatic send(input logic [3:0] op, input logic [63:0] a, b, pc);
        @(negedge clk);
        in_valid = 1'b1; in_opcode = op; in_op_a = a; in_op_b = b; in_next_pc = pc;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_wb(output logic [63:0] res, output logic [3:0] opc);
        int n = 0;
        #1;
        while (!wb_valid && n < 60) begin @(negedge clk); #1; n++; end
        res = wb_result; opc = wb_opcode;
        check("R6 writeback seen", {63'd0, wb_valid}, 64'd1);
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; in_opcode = '0; in_op_a = '0; in_op_b = '0;
        in_next_pc = '0; wb_ready = 1'b1; mc_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R10 wb_valid after reset", {63'd0, wb_valid}, 64'd0);
        check("R10 mc_valid after reset", {63'd0, mc_valid}, 64'd0);
        check("R10 in_ready after reset", {63'd0, in_ready}, 64'd1);
    endtask

    task automatic t_alu(input string req, input logic [3:0] op,
                         input logic [63:0] a, b, pc, exp);
        send(op, a, b, pc);
        check({req, " R11 valid next cycle"}, {63'd0, wb_valid}, 64'd1);
        check({req, " result"}, wb_result, exp);
        check({req, " R4 opcode copy"}, {60'd0, wb_opcode}, {60'd0, op});
    endtask

    task automatic t_load(input logic [63:0] a, b);
        logic [63:0] ea = a + b;
        logic [63:0] r;
        logic [3:0]  o;
        send(4'h5, a, b, 64'h0);
        check("R5 mc_valid", {63'd0, mc_valid}, 64'd1);
        check("R5 line addr", {6'd0, mc_line_addr}, {6'd0, ea[63:6]});
        check("R5 no wb at issue", {63'd0, wb_valid}, 64'd0);
        #1;
        check("R8 in_ready low while parked", {63'd0, in_ready}, 64'd0);
        wait_wb(r, o);
        check("R6 load word", r, exp_word(ea));
        check("R6 load opcode", {60'd0, o}, 64'd5);
    endtask

    task automatic t_priority();
        logic [63:0] ea = 64'h3000 + 64'h0D;
        bit load_seen = 1'b0;
        mem_lat = 4;
        send(4'h5, 64'h3000, 64'h0D, 64'h0);
        in_valid = 1'b1; in_opcode = 4'h3; in_op_a = 64'd100; in_op_b = 64'd23;
        #1;
        while (!in_ready) begin
            if (wb_valid) load_seen = 1'b1;
            @(negedge clk); #1;
        end
        if (wb_valid && wb_opcode == 4'h5) begin
            load_seen = 1'b1;
            check("R8 load result before next issue", wb_result, exp_word(ea));
        end
        check("R8 slot serviced first", {63'd0, load_seen}, 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 add follows load", wb_result, 64'd123);
        mem_lat = 2;
    endtask

    task automatic t_wb_stall();
        @(negedge clk);
        wb_ready = 1'b0;
        send(4'h3, 64'd7, 64'd8, 64'h0);
        in_valid = 1'b1; in_opcode = 4'h4; in_op_a = 64'd1; in_op_b = 64'd2;
        #1;
        check("R7 in_ready low with full wb", {63'd0, in_ready}, 64'd0);
        repeat (3) @(negedge clk);
        check("R9 wb held valid", {63'd0, wb_valid}, 64'd1);
        check("R9 wb held result", wb_result, 64'd15);
        wb_ready = 1'b1;
        #1;
        check("R7 in_ready when wb drains", {63'd0, in_ready}, 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 next result after drain", wb_result, 64'd3);
    endtask

    task automatic t_mc_stall();
        logic [63:0] r;
        logic [3:0]  o;
        @(negedge clk);
        mc_ready = 1'b0;
        send(4'h5, 64'h12340, 64'h8, 64'h0);
        repeat (3) @(negedge clk);
        check("R9 mc held valid", {63'd0, mc_valid}, 64'd1);
        check("R9 mc held addr", {6'd0, mc_line_addr}, {6'd0, 58'(64'h12348 >> 6)});
        mc_ready = 1'b1;
        wait_wb(r, o);
        check("R6 load after cmd stall", r, exp_word(64'h12348));
    endtask

    task automatic t_wb_stall_load();
        logic [63:0] r;
        @(negedge clk);
        wb_ready = 1'b0;
        send(4'h5, 64'h700, 64'h38, 64'h0);
        repeat (8) @(negedge clk);
        r = wb_result;
        check("R9 load result held", {63'd0, wb_valid}, 64'd1);
        repeat (2) @(negedge clk);
        check("R9 load result stable", wb_result, r);
        check("R6 offset 56 word", wb_result, exp_word(64'h738));
        wb_ready = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_alu("R1 jz taken",     4'h1, 64'hAAA0, 64'd0, 64'h104, 64'hAAA0);
        t_alu("R1 jz not taken", 4'h1, 64'hAAA0, 64'd5, 64'h104, 64'h104);
        t_alu("R2 jnz taken",    4'h2, 64'hBEE0, 64'd3, 64'h208, 64'hBEE0);
        t_alu("R2 jnz not taken",4'h2, 64'hBEE0, 64'd0, 64'h208, 64'h208);
        t_alu("R3 add wrap",     4'h3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'h0, 64'd1);
        t_alu("R3 emit sum",     4'h4, 64'd1000, 64'd234, 64'h0, 64'd1234);
        t_alu("R4 unknown zero", 4'hF, 64'd9, 64'd9, 64'h50, 64'd0);
        t_alu("R4 opcode zero",  4'h0, 64'd9, 64'd9, 64'h50, 64'd0);
        t_load(64'h1000, 64'h0);
        t_load(64'h2040, 64'h8);
        t_load(64'h5000, 64'h3);
        mem_lat = 0;
        t_load(64'hABC0, 64'h38);
        mem_lat = 2;
        t_priority();
        t_wb_stall();
        t_mc_stall();
        t_wb_stall_load();
        t_reset();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule